// File: doc/BRIEF.md
# DAC Sample FIFO with Swing-Back Playback

This block sits in front of a digital-to-analog converter's data latch. Samples written by a processor or a DMA engine are queued in a circular buffer. Each conversion trigger moves one sample into the output holding register that drives the converter. The trigger comes either from a hardware trigger pin or from a software strobe.

Three playback modes are available. In bypass mode a write loads the holding register directly. In normal mode the queue is consumed in write order. In swing mode the read pointer walks up to the newest entry and back down to entry zero, again and again, without consuming anything. This suits periodic waveforms that are stored only once.

Status flags report full, empty, watermark, overflow, underflow and swing-pass completion. An interrupt line and a DMA request line are both gated by enables. A held pointer-reset input clears the queue state. Both queue pointers can be read.

Top module: `dac_sample_fifo`

## Requirements
- R1: In normal mode (cfgMode=1), each accepted trigger loads the oldest queued sample into dacOut on the next clock edge and advances rdPtr by one, wrapping at DEPTH. Samples come out in write order, and the empty flag (status bit 1) reads 1 once the queue is drained.
- R2: A trigger that arrives while the queue is empty sets the sticky underflow flag (status bit 4). dacOut and rdPtr stay unchanged.
- R3: A write in a queued mode while the queue holds DEPTH samples sets the sticky overflow flag (status bit 3) and discards the sample. wrPtr does not move. The full flag (status bit 0) reads 1 while DEPTH samples are held.
- R4: Writing 1 to flagClr bit 0 clears overflow, bit 1 clears underflow and bit 2 clears swing-complete. Each flag is cleared one cycle later.
- R5: In swing mode (cfgMode=2), after a pointer reset and N written samples, successive triggers present entries 0,1,…,N-1,N-2,…,1,0,1,… and consume nothing.
- R6: The swing-complete flag (status bit 5) sets on the trigger that returns the read pointer to zero after it has reached the top: the fourth trigger for three entries, and every trigger for a single entry.
- R7: While swing mode is selected, the full, empty and watermark flags (status bits 0 to 2) hold their values. They track the sample count again once another mode is selected.
- R8: The watermark flag (status bit 2) is 1 whenever the held sample count is at or below wmLevel, and 0 otherwise.
- R9: In bypass mode (cfgMode=0 or 3), a write loads wrData into dacOut on the next edge and leaves the queue alone. Triggers have no effect.
- R10: While fifoRst is high, the pointers return to 0, status returns to 6'b000110 and writes and triggers are ignored. dacOut keeps its value. Reset also leaves dacOut at 0 and status at 6'b000110.
- R11: cfgSwTrigSel=1 takes triggers only from swTrig. cfgSwTrigSel=0 takes them only from hwTrig.
- R12: irq is the OR of each status bit ANDed with the same bit of irqEn. dmaReq is (empty AND dmaEnEmpty) OR (watermark AND dmaEnWm).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | 0 bypass, 1 normal queue, 2 swing, 3 treated as bypass |
| cfgSwTrigSel | input | 1 | 1 selects software trigger strobe, 0 the hardware pin |
| wmLevel | input | $clog2(DEPTH+1) | Watermark threshold in samples |
| wrValid | input | 1 | Sample write strobe |
| wrData | input | DW | Sample value |
| hwTrig | input | 1 | Hardware conversion trigger, one trigger per high cycle |
| swTrig | input | 1 | Software conversion trigger strobe |
| fifoRst | input | 1 | Held pointer and flag reset |
| flagClr | input | 3 | Write-one-to-clear: bit0 overflow, bit1 underflow, bit2 swing-complete |
| irqEn | input | 6 | Per-flag interrupt enables, same bit order as status |
| dmaEnEmpty | input | 1 | DMA request on empty enable |
| dmaEnWm | input | 1 | DMA request on watermark enable |
| dacOut | output | DW | Output holding register feeding the converter |
| status | output | 6 | {swingDone, underflow, overflow, watermark, empty, full} |
| wrPtr | output | $clog2(DEPTH) | Write pointer readback |
| rdPtr | output | $clog2(DEPTH) | Read pointer readback |
| irq | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |

## Verification
The bench fills the queue past DEPTH so the write pointer wraps. A design that stored the extra sample, or moved the pointer, shows up as a corrupted drain order or a wrong wrPtr. It triggers an empty queue and a deselected trigger pin, where a faulty design would change dacOut or rdPtr. In swing mode it checks the turn-around at the top and the exact trigger that raises the pass flag, including the single-entry case, where an off-by-one design would repeat the top entry or flag a trigger late. It also checks that writes made during swing leave the level flags frozen until the mode changes.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_FIFO   = 2'd1,
    MODE_SWING  = 2'd2,
    MODE_RSVD   = 2'd3
  } fifoMode_e;

  // strobes from control to datapath, at most one of pop/swingStep per cycle
  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
    logic swingStep;
    logic bypassLoad;
  } dpStrobe_t;

  localparam int FLAG_W     = 6;
  localparam int BIT_FULL   = 0;
  localparam int BIT_EMPTY  = 1;
  localparam int BIT_WM     = 2;
  localparam int BIT_OVF    = 3;
  localparam int BIT_UDF    = 4;
  localparam int BIT_SWDONE = 5;

  // level flags after a pointer reset: watermark set, empty set, full clear
  localparam logic [2:0] LEVEL_INIT = 3'b110;

endpackage

// File: rtl/dacq_ctrl.sv
module dacq_ctrl
  import dacq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic              cfgSwTrigSel,
  input  logic [CW-1:0]     wmLevel,
  input  logic              wrValid,
  input  logic              hwTrig,
  input  logic              swTrig,
  input  logic              fifoRst,
  input  logic [2:0]        flagClr,
  input  logic [FLAG_W-1:0] irqEn,
  input  logic              dmaEnEmpty,
  input  logic              dmaEnWm,
  input  logic [CW-1:0]     count,
  input  logic              swingWrap,
  output dpStrobe_t         strobe,
  output logic [FLAG_W-1:0] status,
  output logic              irq,
  output logic              dmaReq
);

  fifoMode_e mode;
  logic      active;
  logic      trigHit;
  logic      queued;
  logic      isEmpty;
  logic      isFull;
  logic      ovfEvt;
  logic      udfEvt;
  logic [2:0] levelNow;
  logic [2:0] levelHold;
  logic [2:0] levelOut;
  logic      ovfFlag;
  logic      udfFlag;
  logic      swdFlag;

  assign mode    = fifoMode_e'(cfgMode);
  assign active  = !fifoRst;
  assign trigHit = active && (cfgSwTrigSel ? swTrig : hwTrig);
  assign queued  = (mode == MODE_FIFO) || (mode == MODE_SWING);
  assign isEmpty = (count == '0);
  assign isFull  = (count == CW'(DEPTH));

  always_comb begin
    strobe            = '0;
    strobe.clear      = fifoRst;
    strobe.bypassLoad = active && wrValid && !queued;
    strobe.push       = active && wrValid && queued && !isFull;
    strobe.pop        = trigHit && (mode == MODE_FIFO) && !isEmpty;
    strobe.swingStep  = trigHit && (mode == MODE_SWING) && !isEmpty;
  end

  assign ovfEvt = active && wrValid && queued && isFull;
  assign udfEvt = trigHit && queued && isEmpty;

  // level flags, frozen while swinging
  assign levelNow = {(count <= wmLevel), isEmpty, isFull};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  levelHold <= LEVEL_INIT;
    else if (fifoRst)           levelHold <= LEVEL_INIT;
    else if (mode != MODE_SWING) levelHold <= levelNow;
  end

  assign levelOut = (mode == MODE_SWING) ? levelHold : levelNow;

  // sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      udfFlag <= 1'b0;
      swdFlag <= 1'b0;
    end else if (fifoRst) begin
      ovfFlag <= 1'b0;
      udfFlag <= 1'b0;
      swdFlag <= 1'b0;
    end else begin
      ovfFlag <= ovfEvt    || (ovfFlag && !flagClr[0]);
      udfFlag <= udfEvt    || (udfFlag && !flagClr[1]);
      swdFlag <= swingWrap || (swdFlag && !flagClr[2]);
    end
  end

  assign status = {swdFlag, udfFlag, ovfFlag, levelOut};
  assign irq    = |(status & irqEn);
  assign dmaReq = (status[BIT_EMPTY] && dmaEnEmpty) || (status[BIT_WM] && dmaEnWm);

endmodule

// File: rtl/dacq_datapath.sv
module dacq_datapath
  import dacq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] dacOut,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic [CW-1:0] count,
  output logic          swingWrap
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] topIdx;
  logic [PW-1:0] rdSwingNext;
  logic          dirDown;
  logic          dirNext;

  function automatic logic [PW-1:0] incIdx(input logic [PW-1:0] idx);
    return (idx == PW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  // newest written entry is the turn-around point of a swing
  assign topIdx = (wrPtr == '0) ? PW'(DEPTH - 1) : wrPtr - 1'b1;

  always_comb begin
    rdSwingNext = rdPtr;
    dirNext     = dirDown;
    swingWrap   = 1'b0;
    if (topIdx == '0) begin
      rdSwingNext = '0;
      dirNext     = 1'b0;
      swingWrap   = strobe.swingStep;
    end else if (!dirDown) begin
      if (rdPtr >= topIdx) begin
        rdSwingNext = topIdx - 1'b1;
        dirNext     = 1'b1;
        swingWrap   = strobe.swingStep && (topIdx == PW'(1));
        if (topIdx == PW'(1)) dirNext = 1'b0;
      end else begin
        rdSwingNext = rdPtr + 1'b1;
      end
    end else begin
      if (rdPtr <= PW'(1)) begin
        rdSwingNext = '0;
        dirNext     = 1'b0;
        swingWrap   = strobe.swingStep;
      end else begin
        rdSwingNext = rdPtr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      dirDown <= 1'b0;
    end else if (strobe.clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      dirDown <= 1'b0;
    end else begin
      if (strobe.push) wrPtr <= incIdx(wrPtr);
      if (strobe.pop) begin
        rdPtr <= incIdx(rdPtr);
      end else if (strobe.swingStep) begin
        rdPtr   <= rdSwingNext;
        dirDown <= dirNext;
      end
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 dacOut <= '0;
    else if (strobe.bypassLoad)                dacOut <= wrData;
    else if (strobe.pop || strobe.swingStep)   dacOut <= mem[rdPtr];
  end

endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
  import dacq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic              cfgSwTrigSel,
  input  logic [CW-1:0]     wmLevel,
  input  logic              wrValid,
  input  logic [DW-1:0]     wrData,
  input  logic              hwTrig,
  input  logic              swTrig,
  input  logic              fifoRst,
  input  logic [2:0]        flagClr,
  input  logic [FLAG_W-1:0] irqEn,
  input  logic              dmaEnEmpty,
  input  logic              dmaEnWm,
  output logic [DW-1:0]     dacOut,
  output logic [FLAG_W-1:0] status,
  output logic [PW-1:0]     wrPtr,
  output logic [PW-1:0]     rdPtr,
  output logic              irq,
  output logic              dmaReq
);

  dpStrobe_t     strobe;
  logic [CW-1:0] count;
  logic          swingWrap;

  dacq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSwTrigSel(cfgSwTrigSel),
    .wmLevel(wmLevel), .wrValid(wrValid), .hwTrig(hwTrig), .swTrig(swTrig),
    .fifoRst(fifoRst), .flagClr(flagClr), .irqEn(irqEn),
    .dmaEnEmpty(dmaEnEmpty), .dmaEnWm(dmaEnWm), .count(count),
    .swingWrap(swingWrap), .strobe(strobe), .status(status),
    .irq(irq), .dmaReq(dmaReq)
  );

  dacq_datapath #(.DEPTH(DEPTH), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .dacOut(dacOut), .wrPtr(wrPtr), .rdPtr(rdPtr), .count(count),
    .swingWrap(swingWrap)
  );

endmodule

// File: rtl/dacq_checker.sv
module dacq_checker #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int PW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    cfgMode,
  input logic          cfgSwTrigSel,
  input logic          wrValid,
  input logic [DW-1:0] wrData,
  input logic          hwTrig,
  input logic          swTrig,
  input logic          fifoRst,
  input logic [DW-1:0] dacOut,
  input logic [5:0]    status,
  input logic [PW-1:0] wrPtr,
  input logic [PW-1:0] rdPtr
);

  logic trigSel;
  assign trigSel = cfgSwTrigSel ? swTrig : hwTrig;

  // R2
  a_r2_underflow_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd1 && !fifoRst && trigSel && status[1])
    |=> (status[4] && $stable(dacOut) && $stable(rdPtr)));

  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd1 && !fifoRst && wrValid && status[0])
    |=> (status[3] && $stable(wrPtr)));

  // R7
  a_r7_swing_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd2 && !fifoRst)
    |=> (cfgMode != 2'd2 || $stable(status[2:0])));

  // R9
  a_r9_bypass_load: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd0 && wrValid && !fifoRst)
    |=> (dacOut == $past(wrData) && $stable(wrPtr)));

  // R10
  a_r10_ptr_reset: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |=> (wrPtr == '0 && rdPtr == '0 && status == 6'b000110));

endmodule

bind dac_sample_fifo dacq_checker #(.DEPTH(DEPTH), .DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSwTrigSel(cfgSwTrigSel),
  .wrValid(wrValid), .wrData(wrData), .hwTrig(hwTrig), .swTrig(swTrig),
  .fifoRst(fifoRst), .dacOut(dacOut), .status(status), .wrPtr(wrPtr),
  .rdPtr(rdPtr)
);

// File: tb/tb_dac_sample_fifo.sv
module tb_dac_sample_fifo;

  localparam int DEPTH = 16;
  localparam int DW    = 12;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    cfgMode = 2'd1;
  logic          cfgSwTrigSel = 1'b0;
  logic [CW-1:0] wmLevel = CW'(4);
  logic          wrValid = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          hwTrig = 1'b0;
  logic          swTrig = 1'b0;
  logic          fifoRst = 1'b0;
  logic [2:0]    flagClr = '0;
  logic [5:0]    irqEn = '0;
  logic          dmaEnEmpty = 1'b0;
  logic          dmaEnWm = 1'b0;
  logic [DW-1:0] dacOut;
  logic [5:0]    status;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic          irq;
  logic          dmaReq;

  int numChecks = 0;
  int numFails  = 0;

  logic [DW-1:0] expQ[$];
  string         tagQ[$];
  logic          pendCmp = 1'b0;
  logic          armed   = 1'b0;

  always #5 clk = ~clk;

  dac_sample_fifo #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSwTrigSel(cfgSwTrigSel),
    .wmLevel(wmLevel), .wrValid(wrValid), .wrData(wrData), .hwTrig(hwTrig),
    .swTrig(swTrig), .fifoRst(fifoRst), .flagClr(flagClr), .irqEn(irqEn),
    .dmaEnEmpty(dmaEnEmpty), .dmaEnWm(dmaEnWm), .dacOut(dacOut),
    .status(status), .wrPtr(wrPtr), .rdPtr(rdPtr), .irq(irq), .dmaReq(dmaReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pushSample(input logic [DW-1:0] v);
    wrValid = 1'b1;
    wrData  = v;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // driver: records the expected holding-register value, then pulses a trigger pin
  task automatic fire(input logic [DW-1:0] expVal, input bit softPin, input string tag);
    expQ.push_back(expVal);
    tagQ.push_back(tag);
    pendCmp = 1'b1;
    if (softPin) swTrig = 1'b1;
    else         hwTrig = 1'b1;
    @(negedge clk);
    swTrig  = 1'b0;
    hwTrig  = 1'b0;
    pendCmp = 1'b0;
  endtask

  // monitor: one edge after each trigger, compare against the scoreboard head
  always @(posedge clk) armed <= pendCmp;

  always @(negedge clk) begin
    if (armed) begin
      if (expQ.size() == 0) begin
        check("R1 scoreboard empty", 32'(dacOut), 32'hFFFF_FFFF);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, 32'(dacOut), 32'(e));
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    numFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R10 reset state
    check("R10 status after reset", 32'(status), 32'h06);
    check("R10 wrPtr after reset", 32'(wrPtr), 0);
    check("R10 dacOut after reset", 32'(dacOut), 0);

    // R8 watermark around the threshold of 4
    for (int i = 0; i < 4; i++) pushSample(DW'(12'h100 + i));
    check("R8 wm at count 4", 32'(status[2]), 1);
    pushSample(12'h104);
    check("R8 wm at count 5", 32'(status[2]), 0);
    check("R1 wrPtr after 5 writes", 32'(wrPtr), 5);

    // R1 normal playback on hardware pin
    fire(12'h100, 1'b0, "R1 pop A0");
    fire(12'h101, 1'b0, "R1 pop A1");
    check("R8 wm after pops", 32'(status[2]), 1);
    check("R1 rdPtr", 32'(rdPtr), 2);

    // R11 trigger source select
    cfgSwTrigSel = 1'b1;
    fire(12'h101, 1'b0, "R11 hw pin ignored");
    check("R11 rdPtr unchanged", 32'(rdPtr), 2);
    fire(12'h102, 1'b1, "R11 sw pop");
    fire(12'h103, 1'b1, "R1 pop A3");
    fire(12'h104, 1'b1, "R1 pop A4");
    check("R1 empty flag", 32'(status[1]), 1);

    // R2 underflow
    fire(12'h104, 1'b1, "R2 dacOut held");
    check("R2 underflow flag", 32'(status[4]), 1);
    check("R2 rdPtr held", 32'(rdPtr), 5);

    // R12 interrupt and DMA gating
    irqEn = 6'b010000;
    step();
    check("R12 irq on underflow", 32'(irq), 1);
    irqEn = 6'b000000;
    step();
    check("R12 irq masked", 32'(irq), 0);
    dmaEnEmpty = 1'b1;
    step();
    check("R12 dma on empty", 32'(dmaReq), 1);
    dmaEnEmpty = 1'b0;

    // R4 clear underflow via flagClr bit 1
    flagClr = 3'b010;
    step();
    flagClr = 3'b000;
    check("R4 underflow cleared", 32'(status[4]), 0);

    // R3 fill to full with wrap, then overflow
    for (int i = 0; i < DEPTH; i++) pushSample(DW'(12'h200 + i));
    check("R3 full flag", 32'(status[0]), 1);
    check("R3 wrPtr wrapped", 32'(wrPtr), 5);
    pushSample(12'hFFF);
    check("R3 overflow flag", 32'(status[3]), 1);
    check("R3 wrPtr held", 32'(wrPtr), 5);
    dmaEnWm = 1'b1;
    step();
    check("R12 no dma above wm", 32'(dmaReq), 0);
    dmaEnWm = 1'b0;
    for (int i = 0; i < DEPTH; i++) fire(DW'(12'h200 + i), 1'b1, "R3 drain order");
    check("R3 empty after drain", 32'(status[1]), 1);

    // R4 clear overflow via flagClr bit 0
    flagClr = 3'b001;
    step();
    flagClr = 3'b000;
    check("R4 overflow cleared", 32'(status[3]), 0);

    // R10 pointer reset held, writes ignored
    fire(12'h20F, 1'b1, "R2 dacOut held again");
    pushSample(12'h321);
    fifoRst = 1'b1;
    wrValid = 1'b1;
    wrData  = 12'h777;
    step();
    step();
    wrValid = 1'b0;
    fifoRst = 1'b0;
    step();
    check("R10 wrPtr cleared", 32'(wrPtr), 0);
    check("R10 rdPtr cleared", 32'(rdPtr), 0);
    check("R10 status cleared", 32'(status), 32'h06);
    check("R10 dacOut kept", 32'(dacOut), 32'h20F);

    // R5/R6 swing with three entries
    pushSample(12'h0A0);
    pushSample(12'h0A1);
    pushSample(12'h0A2);
    cfgMode = 2'd2;
    step();
    fire(12'h0A0, 1'b1, "R5 swing 0");
    fire(12'h0A1, 1'b1, "R5 swing 1");
    fire(12'h0A2, 1'b1, "R5 swing 2");
    check("R6 no pass yet", 32'(status[5]), 0);
    fire(12'h0A1, 1'b1, "R5 swing back 1");
    check("R6 pass on fourth", 32'(status[5]), 1);
    check("R5 rdPtr at zero", 32'(rdPtr), 0);
    fire(12'h0A0, 1'b1, "R5 swing 0 again");
    check("R5 rdPtr rising", 32'(rdPtr), 1);
    fire(12'h0A1, 1'b1, "R5 swing 1 again");

    // R7 frozen level flags during swing
    pushSample(12'h0A3);
    pushSample(12'h0A4);
    check("R7 levels frozen", 32'(status[2:0]), 32'b100);
    cfgMode = 2'd1;
    step();
    check("R7 wm tracks after swing", 32'(status[2]), 0);

    // R4 clear swing-complete via flagClr bit 2
    flagClr = 3'b100;
    step();
    flagClr = 3'b000;
    check("R4 swing flag cleared", 32'(status[5]), 0);

    // R9 bypass
    cfgMode = 2'd0;
    step();
    pushSample(12'h5A5);
    check("R9 bypass load", 32'(dacOut), 32'h5A5);
    check("R9 wrPtr untouched", 32'(wrPtr), 5);
    fire(12'h5A5, 1'b1, "R9 trigger ignored");
    check("R9 rdPtr untouched", 32'(rdPtr), 2);

    // R6 single-entry swing
    fifoRst = 1'b1;
    step();
    fifoRst = 1'b0;
    cfgMode = 2'd1;
    step();
    pushSample(12'h0C3);
    cfgMode = 2'd2;
    step();
    fire(12'h0C3, 1'b1, "R6 single entry out");
    check("R6 single entry pass", 32'(status[5]), 1);
    check("R5 single entry rdPtr", 32'(rdPtr), 0);

    repeat (3) step();
    check("R1 scoreboard drained", 32'(expQ.size()), 0);
    summary();
    $finish;
  end

endmodule